// File: doc/BRIEF.md
# Three-Product Split Multiplier

This block is a purely combinational unsigned multiplier with two W-bit operands (8 bits by default) and one 2W-bit product. Each operand is cut into an upper and a lower half. The block then forms the result from three half-size multiplications rather than the four of a plain schoolbook split.

The three products are the upper halves multiplied together, the lower halves multiplied together, and the product of the two half-sums. The cross term is the half-sum product minus the other two. The output is the upper product moved up W bits, plus the cross term moved up W/2 bits, plus the lower product.

The output settles from the operands alone. No clock, enable or handshake takes part, so any register stage belongs to the surrounding logic.

Top module: `karatsuba_mul`

## Requirements
- R1: Operands are split at bit W/2. With both upper halves zero, the product equals the product of the lower halves. For example, 0x0F × 0x0F gives 0x00E1.
- R2: The product of the upper halves is weighted by 2^W. For example, 0xF0 × 0xF0 gives 0xE100.
- R3: The cross term is the half-sum product minus the upper and lower products. It equals upper-of-a × lower-of-b plus lower-of-a × upper-of-b, and is weighted by 2^(W/2). For example, 0xF0 × 0x0F gives 0x0E10.
- R4: The half-sums keep their carry bit (W/2+1 bits), and the cross term loses no bits before the final addition. For example, 0xFF × 0xFF gives 0xFE01.
- R5: For every pair of W-bit operands, the product equals the exact unsigned product.
- R6: When either operand is zero, the product is zero.
- R7: The product follows an operand change with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| prod | output | 2W | Unsigned product |

## Verification
The hardest case to reach is a half-sum that carries into its extra bit while the cross subtraction sits at its largest value. This needs both halves of both operands near all ones, as in 0xFF × 0xFF or 0xF8 × 0x8F. Directed vectors hit those corners first. A full sweep of all 65536 operand pairs then covers every carry and borrow combination in the middle term. Each pair is checked against a behavioural product taken from a queue.

// File: rtl/karatsuba_mul.sv
module karatsuba_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  localparam int H  = W / 2;
  localparam int SW = H + 1;
  localparam int PW = 2 * SW;
  localparam int OW = 2 * W;

  logic [H-1:0]   a_hi, a_lo, b_hi, b_lo;
  logic [2*H-1:0] pp_hi, pp_lo;
  logic [SW-1:0]  sum_a, sum_b;
  logic [PW-1:0]  pp_sum, pp_mid;

  assign {a_hi, a_lo} = op_a;
  assign {b_hi, b_lo} = op_b;

  assign pp_hi  = (2*H)'(a_hi) * (2*H)'(b_hi);
  assign pp_lo  = (2*H)'(a_lo) * (2*H)'(b_lo);
  assign sum_a  = SW'(a_hi) + SW'(a_lo);
  assign sum_b  = SW'(b_hi) + SW'(b_lo);
  assign pp_sum = PW'(sum_a) * PW'(sum_b);
  assign pp_mid = pp_sum - PW'(pp_hi) - PW'(pp_lo);

  assign prod = {pp_hi, pp_lo} + (OW'(pp_mid) << H);

  always_comb begin
    a_r3_mid_cross: assert (pp_mid == PW'(a_hi) * PW'(b_lo) + PW'(a_lo) * PW'(b_hi))
      else $error("cross term mismatch");
    a_r4_no_underflow: assert (pp_sum >= PW'(pp_hi) + PW'(pp_lo))
      else $error("cross subtraction underflow");
    a_r2_hi_weight: assert (prod[OW-1:W] >= W'(pp_hi))
      else $error("upper product lost weight");
    a_r5_exact: assert (prod == OW'(op_a) * OW'(op_b))
      else $error("product not exact");
    a_r6_zero: assert (!(op_a == '0 || op_b == '0) || prod == '0)
      else $error("zero operand gave nonzero product");
  end
endmodule

// File: tb/karatsuba_mul_bench.sv
module karatsuba_mul_bench;
  logic clk = 1'b0;
  logic [7:0]  op_a, op_b;
  logic [15:0] prod;
  int checks = 0, failures = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  karatsuba_mul #(.W(8)) u_karatsuba_mul (.op_a(op_a), .op_b(op_b), .prod(prod));

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic apply(input int a, input int b, input string req);
    int e;
    @(posedge clk);
    #1;
    op_a = 8'(a);
    op_b = 8'(b);
    exp_q.push_back(a * b);
    @(negedge clk);
    e = exp_q.pop_front();
    check(req, int'(prod), e);
  endtask

  initial begin
    op_a = '0;
    op_b = '0;
    #2;
    check("R6 reset state", int'(prod), 0);
    apply(8'h0F, 8'h0F, "R1");
    apply(8'h03, 8'h0C, "R1");
    apply(8'hF0, 8'hF0, "R2");
    apply(8'h10, 8'h10, "R2");
    apply(8'hF0, 8'h0F, "R3");
    apply(8'h0F, 8'hF0, "R3");
    apply(8'hFF, 8'hFF, "R4");
    apply(8'hF8, 8'h8F, "R4");
    apply(8'h00, 8'hFF, "R6");
    apply(8'hA5, 8'h00, "R6");
    @(negedge clk);
    op_a = 8'd200;
    op_b = 8'd3;
    #1;
    check("R7 no clock", int'(prod), 600);
    op_b = 8'd7;
    #1;
    check("R7 no clock", int'(prod), 1400);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(a, b, "R5");
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule